// File: doc/BRIEF.md
# Priority Peripheral Pin Crossbar

This block places the signals of a fixed set of on-chip peripherals onto a bank of general-purpose pins. Two serial ports, a two-wire serial bus and two external interrupt lines can each be enabled on their own. Every enabled signal takes the lowest-numbered pin that is still free, in a fixed priority order. A pin is not free when an earlier signal already holds it, when it is configured as an analog input, or when the external memory interface reserves it for its strobes. No pin is assigned until a global enable is set.

The assignment is computed combinationally from the configuration and captured in a register once per clock. Output data and drive enables are then routed through that registered map, and pin levels are routed back to the peripheral inputs through it. Pins with no peripheral signal behave as plain port-latch outputs. An overflow flag shows that at least one enabled signal found no pin. Pins are numbered 0 to 15: pin p is bit p mod 8 of port p/8, so pin 8 is bit 0 of port 1.

Top module: `pin_crossbar`

## Requirements
- R1: Signals in priority order TX0, RX0, SDA, SCL, TX1, RX1, INT0, INT1 each take the lowest-numbered free pin. pin_sel gives 4 bits per pin at bits [4p+3:4p]: 0 is port latch, and 1 to 8 are those signals in that order. No signal appears on more than one pin.
- R2: With mem_low = 1, pins 6 and 7 are skipped and keep code 0.
- R3: With mem_low = 1 and mem_mux = 1, pin 5 is skipped as well. mem_mux alone skips nothing.
- R4: A pin whose digital_mask bit is 0 is skipped and keeps code 0.
- R5: With xbar_en = 0, every pin has code 0 and every routed input to the peripherals reads 1.
- R6: A code-0 pin drives pin_out = port_latch bit, with pin_oe = push_pull bit OR NOT port_latch bit.
- R7: A TX0 or TX1 pin drives pin_out = transmit data, with pin_oe = push_pull bit OR NOT data. An RX0, RX1, INT0 or INT1 pin has pin_oe = 0 and pin_out = 1.
- R8: An SDA or SCL pin drives pin_out = bus data, with pin_oe = NOT bus data, so it drives only a low level.
- R9: rx0_dat, sda_rd, scl_rd, rx1_dat, int0_n and int1_n follow pin_in at the pin that holds their signal. Each reads 1 when its signal holds no pin.
- R10: overflow is 1 exactly when some enabled signal received no pin, with xbar_en = 1.
- R11: A configuration change reaches pin_sel and overflow at the following clock edge, not before.
- R12: During reset, every code is 0 and overflow is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| xbar_en | input | 1 | Global crossbar enable |
| uart0_en | input | 1 | Enables TX0 and RX0 |
| bus_en | input | 1 | Enables SDA and SCL |
| uart1_en | input | 1 | Enables TX1 and RX1 |
| int0_en | input | 1 | Enables INT0 |
| int1_en | input | 1 | Enables INT1 |
| mem_low | input | 1 | External memory uses the low port strobes |
| mem_mux | input | 1 | External memory in multiplexed address/data mode |
| digital_mask | input | 16 | Per pin: 1 digital, 0 analog (skipped) |
| push_pull | input | 16 | Per pin: 1 push-pull, 0 open-drain |
| port_latch | input | 16 | Port latch value for unassigned pins |
| tx0_dat | input | 1 | Serial port 0 transmit data |
| sda_dat | input | 1 | Serial bus data output |
| scl_dat | input | 1 | Serial bus clock output |
| tx1_dat | input | 1 | Serial port 1 transmit data |
| pin_in | input | 16 | Levels sensed at the pins |
| pin_out | output | 16 | Output data per pin |
| pin_oe | output | 16 | Drive enable per pin |
| pin_sel | output | 64 | Registered 4-bit source code per pin |
| rx0_dat | output | 1 | Routed serial port 0 receive input |
| sda_rd | output | 1 | Routed serial bus data input |
| scl_rd | output | 1 | Routed serial bus clock input |
| rx1_dat | output | 1 | Routed serial port 1 receive input |
| int0_n | output | 1 | Routed interrupt 0 input |
| int1_n | output | 1 | Routed interrupt 1 input |
| overflow | output | 1 | Some enabled signal has no pin |

## Verification
The bench builds the block with its default parameters: 16 pins, with the strobe pins at positions 5, 6 and 7. With eight signals competing for 16 pins, random analog masks that clear many bits reach the overflow case, and sparse masks push late signals such as INT1 into port 1. Fixed masks cover the shipped example, memory skipping with and without multiplexed mode, and a masked bank with only four digital pins.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int NSIG   = 8;
  localparam int NIN    = 6;
  localparam int CODE_W = 4;
  localparam int SIDX_W = $clog2(NSIG);

  typedef logic [CODE_W-1:0] code_t;

  localparam code_t SEL_GPIO = 4'd0;
  localparam code_t SEL_TX0  = 4'd1;
  localparam code_t SEL_RX0  = 4'd2;
  localparam code_t SEL_SDA  = 4'd3;
  localparam code_t SEL_SCL  = 4'd4;
  localparam code_t SEL_TX1  = 4'd5;
  localparam code_t SEL_RX1  = 4'd6;
  localparam code_t SEL_INT0 = 4'd7;
  localparam code_t SEL_INT1 = 4'd8;

  // code carried by the k-th peripheral input (rx0, sda, scl, rx1, int0, int1)
  function automatic code_t in_code(input int k);
    case (k)
      0:       in_code = SEL_RX0;
      1:       in_code = SEL_SDA;
      2:       in_code = SEL_SCL;
      3:       in_code = SEL_RX1;
      4:       in_code = SEL_INT0;
      default: in_code = SEL_INT1;
    endcase
  endfunction
endpackage

// File: rtl/xbar_alloc.sv
module xbar_alloc
  import xbar_pkg::*;
#(
  parameter int NUM_PINS = 16,
  localparam int PIN_W = $clog2(NUM_PINS)
) (
  input  logic [NSIG-1:0]                req,
  input  logic [NUM_PINS-1:0]            skip,
  output logic [NSIG-1:0]                got,
  output logic [NSIG-1:0][PIN_W-1:0]     where
);
  for (genvar s = 0; s < NSIG; s++) begin : g_stage
    logic [NUM_PINS-1:0] prev;
    logic [NUM_PINS-1:0] nxt;
    logic [PIN_W-1:0]    idx;
    logic                any;

    if (s == 0) begin : g_first
      assign prev = skip;
    end else begin : g_chain
      assign prev = g_stage[s-1].nxt;
    end

    // lowest free pin for this signal
    always_comb begin
      idx = '0;
      any = 1'b0;
      for (int p = NUM_PINS - 1; p >= 0; p--) begin
        if (!prev[p]) begin
          idx = PIN_W'(p);
          any = 1'b1;
        end
      end
    end

    assign got[s]   = req[s] & any;
    assign where[s] = idx;

    always_comb begin
      nxt = prev;
      if (got[s]) nxt[idx] = 1'b1;
    end
  end
endmodule

// File: rtl/xbar_map_reg.sv
module xbar_map_reg
  import xbar_pkg::*;
#(
  parameter int NUM_PINS = 16,
  localparam int PIN_W = $clog2(NUM_PINS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NSIG-1:0]                  req,
  input  logic [NSIG-1:0]                  got,
  input  logic [NSIG-1:0][PIN_W-1:0]       where,
  output logic [NUM_PINS-1:0][CODE_W-1:0]  code_q,
  output logic                             ovf_q
);
  logic [NUM_PINS-1:0][CODE_W-1:0] code_d;
  logic                            ovf_d;
  logic                            map_en;

  assign map_en = 1'b1;

  always_comb begin
    code_d = '0;
    for (int s = 0; s < NSIG; s++) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (got[s] && where[s] == PIN_W'(p)) code_d[p] = CODE_W'(s + 1);
      end
    end
    ovf_d = |(req & ~got);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      ovf_q  <= 1'b0;
    end else if (map_en) begin
      code_q <= code_d;
      ovf_q  <= ovf_d;
    end
  end
endmodule

// File: rtl/xbar_pin_mux.sv
module xbar_pin_mux
  import xbar_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_PINS-1:0][CODE_W-1:0]  code,
  input  logic [NUM_PINS-1:0]              latch,
  input  logic [NUM_PINS-1:0]              pp,
  input  logic [NSIG-1:0]                  sig_dat,
  output logic [NUM_PINS-1:0]              out,
  output logic [NUM_PINS-1:0]              oe
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic d;

    assign d = sig_dat[SIDX_W'(code[p] - 4'd1)];

    always_comb begin
      case (code[p])
        SEL_TX0, SEL_TX1: begin
          out[p] = d;
          oe[p]  = pp[p] | ~d;
        end
        SEL_SDA, SEL_SCL: begin
          out[p] = d;
          oe[p]  = ~d;
        end
        SEL_RX0, SEL_RX1, SEL_INT0, SEL_INT1: begin
          out[p] = 1'b1;
          oe[p]  = 1'b0;
        end
        default: begin
          out[p] = latch[p];
          oe[p]  = pp[p] | ~latch[p];
        end
      endcase
    end

    // R8
    bus_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((code[p] == SEL_SDA || code[p] == SEL_SCL) && oe[p]) |-> !out[p]);

    // R7
    input_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (code[p] == SEL_RX0 || code[p] == SEL_RX1 ||
       code[p] == SEL_INT0 || code[p] == SEL_INT1) |-> !oe[p]);
  end
endmodule

// File: rtl/xbar_in_route.sv
module xbar_in_route
  import xbar_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic [NUM_PINS-1:0][CODE_W-1:0]  code,
  input  logic [NUM_PINS-1:0]              pin_in,
  output logic [NIN-1:0]                   sig_in
);
  for (genvar k = 0; k < NIN; k++) begin : g_in
    always_comb begin
      sig_in[k] = 1'b1;
      for (int p = 0; p < NUM_PINS; p++) begin
        if (code[p] == in_code(k)) sig_in[k] = pin_in[p];
      end
    end
  end
endmodule

// File: rtl/pin_crossbar.sv
module pin_crossbar
  import xbar_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int ALE_PIN  = 5,
  parameter int RD_PIN   = 6,
  parameter int WR_PIN   = 7,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       xbar_en,
  input  logic                       uart0_en,
  input  logic                       bus_en,
  input  logic                       uart1_en,
  input  logic                       int0_en,
  input  logic                       int1_en,
  input  logic                       mem_low,
  input  logic                       mem_mux,
  input  logic [NUM_PINS-1:0]        digital_mask,
  input  logic [NUM_PINS-1:0]        push_pull,
  input  logic [NUM_PINS-1:0]        port_latch,
  input  logic                       tx0_dat,
  input  logic                       sda_dat,
  input  logic                       scl_dat,
  input  logic                       tx1_dat,
  input  logic [NUM_PINS-1:0]        pin_in,
  output logic [NUM_PINS-1:0]        pin_out,
  output logic [NUM_PINS-1:0]        pin_oe,
  output logic [NUM_PINS*CODE_W-1:0] pin_sel,
  output logic                       rx0_dat,
  output logic                       sda_rd,
  output logic                       scl_rd,
  output logic                       rx1_dat,
  output logic                       int0_n,
  output logic                       int1_n,
  output logic                       overflow
);
  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  // requests and skipped pins
  logic [NSIG-1:0]     req;
  logic [NUM_PINS-1:0] skip;

  assign req = {int1_en, int0_en, uart1_en, uart1_en,
                bus_en, bus_en, uart0_en, uart0_en} & {NSIG{xbar_en}};

  always_comb begin
    skip = ~digital_mask;
    if (mem_low) begin
      skip[RD_PIN] = 1'b1;
      skip[WR_PIN] = 1'b1;
      if (mem_mux) skip[ALE_PIN] = 1'b1;
    end
  end

  logic [NSIG-1:0]                 got;
  logic [NSIG-1:0][PIN_W-1:0]      where;
  logic [NUM_PINS-1:0][CODE_W-1:0] code_q;
  logic [NSIG-1:0]                 sig_dat;
  logic [NIN-1:0]                  sig_in;

  xbar_alloc #(.NUM_PINS(NUM_PINS)) i_alloc (
    .req   (req),
    .skip  (skip),
    .got   (got),
    .where (where)
  );

  xbar_map_reg #(.NUM_PINS(NUM_PINS)) i_map (
    .clk    (clk),
    .rst_n  (rst_ni),
    .req    (req),
    .got    (got),
    .where  (where),
    .code_q (code_q),
    .ovf_q  (overflow)
  );

  assign sig_dat = {1'b1, 1'b1, 1'b1, tx1_dat, scl_dat, sda_dat, 1'b1, tx0_dat};

  xbar_pin_mux #(.NUM_PINS(NUM_PINS)) i_mux (
    .clk     (clk),
    .rst_n   (rst_ni),
    .code    (code_q),
    .latch   (port_latch),
    .pp      (push_pull),
    .sig_dat (sig_dat),
    .out     (pin_out),
    .oe      (pin_oe)
  );

  xbar_in_route #(.NUM_PINS(NUM_PINS)) i_in (
    .code   (code_q),
    .pin_in (pin_in),
    .sig_in (sig_in)
  );

  assign pin_sel = code_q;
  assign rx0_dat = sig_in[0];
  assign sda_rd  = sig_in[1];
  assign scl_rd  = sig_in[2];
  assign rx1_dat = sig_in[3];
  assign int0_n  = sig_in[4];
  assign int1_n  = sig_in[5];

  // checks on the registered map
  logic [NUM_PINS-1:0] pin_used;
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_used
    assign pin_used[p] = (code_q[p] != SEL_GPIO);

    // R4
    analog_skip_chk: assert property (@(posedge clk) disable iff (!rst_ni)
      !digital_mask[p] |=> (code_q[p] == SEL_GPIO));
  end

  for (genvar s = 0; s < NSIG; s++) begin : g_sig
    logic [NUM_PINS-1:0] hold;
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_hold
      assign hold[p] = (code_q[p] == CODE_W'(s + 1));
    end

    // R1
    unique_pin_chk: assert property (@(posedge clk) disable iff (!rst_ni)
      $onehot0(hold));
  end

  // R5
  xbar_off_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !xbar_en |=> (pin_sel == '0));

  // R2
  strobe_skip_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_low |=> (code_q[RD_PIN] == SEL_GPIO && code_q[WR_PIN] == SEL_GPIO));

  // R3
  ale_skip_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_low && mem_mux) |=> (code_q[ALE_PIN] == SEL_GPIO));

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    overflow |-> &(pin_used | $past(skip)));
endmodule

// File: tb/test_pin_crossbar.sv
module test_pin_crossbar;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        xbar_en, uart0_en, bus_en, uart1_en, int0_en, int1_en;
  logic        mem_low, mem_mux;
  logic [15:0] digital_mask, push_pull, port_latch, pin_in;
  logic        tx0_dat, sda_dat, scl_dat, tx1_dat;
  logic [15:0] pin_out, pin_oe;
  logic [63:0] pin_sel;
  logic        rx0_dat, sda_rd, scl_rd, rx1_dat, int0_n, int1_n, overflow;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pin_crossbar i_pin_crossbar (
    .clk(clk), .rst_n(rst_n), .xbar_en(xbar_en), .uart0_en(uart0_en),
    .bus_en(bus_en), .uart1_en(uart1_en), .int0_en(int0_en), .int1_en(int1_en),
    .mem_low(mem_low), .mem_mux(mem_mux), .digital_mask(digital_mask),
    .push_pull(push_pull), .port_latch(port_latch), .tx0_dat(tx0_dat),
    .sda_dat(sda_dat), .scl_dat(scl_dat), .tx1_dat(tx1_dat), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_sel(pin_sel), .rx0_dat(rx0_dat),
    .sda_rd(sda_rd), .scl_rd(scl_rd), .rx1_dat(rx1_dat), .int0_n(int0_n),
    .int1_n(int1_n), .overflow(overflow)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // model of the map from the requirements: walk a pointer through the pins
  logic [63:0] m_sel;
  logic        m_ovf;
  task automatic model();
    logic [15:0] sk;
    logic [7:0]  rq;
    int ptr;
    sk = ~digital_mask;
    if (mem_low) begin sk[6] = 1'b1; sk[7] = 1'b1; if (mem_mux) sk[5] = 1'b1; end
    rq = {int1_en, int0_en, uart1_en, uart1_en, bus_en, bus_en, uart0_en, uart0_en};
    if (!xbar_en) rq = '0;
    m_sel = '0; m_ovf = 1'b0; ptr = 0;
    for (int s = 0; s < 8; s++) begin
      if (rq[s]) begin
        while (ptr < 16 && sk[ptr]) ptr++;
        if (ptr < 16) begin m_sel[ptr*4 +: 4] = 4'(s + 1); ptr++; end
        else m_ovf = 1'b1;
      end
    end
  endtask

  function automatic logic in_exp(input logic [3:0] c);
    in_exp = 1'b1;
    for (int p = 0; p < 16; p++) if (m_sel[p*4 +: 4] == c) in_exp = pin_in[p];
  endfunction

  task automatic check_drive();
    for (int p = 0; p < 16; p++) begin
      logic [3:0] c;
      logic eo, ee, d;
      string tag;
      c = m_sel[p*4 +: 4];
      case (c)
        4'd0: begin tag = "R6"; eo = port_latch[p]; ee = push_pull[p] | ~port_latch[p]; end
        4'd1, 4'd5: begin
          tag = "R7"; d = (c == 4'd1) ? tx0_dat : tx1_dat;
          eo = d; ee = push_pull[p] | ~d;
        end
        4'd3, 4'd4: begin
          tag = "R8"; d = (c == 4'd3) ? sda_dat : scl_dat;
          eo = d; ee = ~d;
        end
        default: begin tag = "R7"; eo = 1'b1; ee = 1'b0; end
      endcase
      chk($sformatf("%s pin %0d out/oe", tag, p), {62'd0, pin_out[p], pin_oe[p]}, {62'd0, eo, ee});
    end
  endtask

  task automatic check_inputs();
    chk("R9 routed inputs", {58'd0, rx0_dat, sda_rd, scl_rd, rx1_dat, int0_n, int1_n},
        {58'd0, in_exp(4'd2), in_exp(4'd3), in_exp(4'd4), in_exp(4'd6), in_exp(4'd7), in_exp(4'd8)});
  endtask

  task automatic check_all(input string tag);
    model();
    chk({tag, " pin_sel"}, pin_sel, m_sel);
    chk("R10 overflow", {63'd0, overflow}, {63'd0, m_ovf});
    check_drive();
    check_inputs();
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic all_on();
    xbar_en = 1; uart0_en = 1; bus_en = 1; uart1_en = 1; int0_en = 1; int1_en = 1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] ex;
    void'($urandom(32'd20240611));
    rst_n = 0;
    xbar_en = 0; uart0_en = 0; bus_en = 0; uart1_en = 0; int0_en = 0; int1_en = 0;
    mem_low = 0; mem_mux = 0; digital_mask = '1; push_pull = '0; port_latch = '1;
    pin_in = '0; tx0_dat = 1; sda_dat = 1; scl_dat = 1; tx1_dat = 1;
    repeat (3) @(negedge clk);
    // R12 reset state, even with configuration asking for pins
    all_on();
    step();
    chk("R12 reset pin_sel", pin_sel, 64'd0);
    chk("R12 reset overflow", {63'd0, overflow}, 64'd0);
    rst_n = 1;
    repeat (4) step();

    // R1 shipped example: memory low & multiplexed, pins 10..12 analog
    mem_low = 1; mem_mux = 1; digital_mask = 16'hE3FF; pin_in = 16'h5A3C;
    step();
    ex = '0;
    ex[0*4 +: 4] = 1; ex[1*4 +: 4] = 2; ex[2*4 +: 4] = 3; ex[3*4 +: 4] = 4;
    ex[4*4 +: 4] = 5; ex[8*4 +: 4] = 6; ex[9*4 +: 4] = 7; ex[13*4 +: 4] = 8;
    chk("R1 example map", pin_sel, ex);
    check_all("R4");
    chk("R9 rx1 from pin 8", {63'd0, rx1_dat}, {63'd0, pin_in[8]});

    // R11 change shows only after the next edge
    mem_low = 0; mem_mux = 0; digital_mask = '1;
    #1;
    chk("R11 map held before edge", pin_sel, ex);
    step();
    ex = '0;
    for (int s = 0; s < 8; s++) ex[s*4 +: 4] = 4'(s + 1);
    chk("R11 map after edge", pin_sel, ex);

    // R2 strobes only
    mem_low = 1; step();
    ex = '0;
    for (int s = 0; s < 6; s++) ex[s*4 +: 4] = 4'(s + 1);
    ex[8*4 +: 4] = 7; ex[9*4 +: 4] = 8;
    chk("R2 strobe pins skipped", pin_sel, ex);
    check_all("R2");

    // R3 multiplexed flag alone skips nothing
    mem_low = 0; mem_mux = 1; step();
    ex = '0;
    for (int s = 0; s < 8; s++) ex[s*4 +: 4] = 4'(s + 1);
    chk("R3 mux alone no skip", pin_sel, ex);
    mem_low = 1; step();
    check_all("R3");
    chk("R3 pin 5 free", {60'd0, pin_sel[5*4 +: 4]}, 64'd0);

    // R10 only four digital pins
    mem_low = 0; mem_mux = 0; digital_mask = 16'h000F; step();
    chk("R10 overflow set", {63'd0, overflow}, 64'd1);
    check_all("R10");

    // R5 crossbar off
    xbar_en = 0; digital_mask = '1; pin_in = '0; step();
    chk("R5 no pins assigned", pin_sel, 64'd0);
    chk("R5 inputs idle", {58'd0, rx0_dat, sda_rd, scl_rd, rx1_dat, int0_n, int1_n}, 64'h3F);
    check_all("R5");

    // random configurations
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      xbar_en = (r[3:0] != 0); uart0_en = r[4]; bus_en = r[5]; uart1_en = r[6];
      int0_en = r[7]; int1_en = r[8]; mem_low = r[9]; mem_mux = r[10];
      digital_mask = r[11] ? 16'($urandom) : 16'($urandom | $urandom);
      push_pull = 16'($urandom); port_latch = 16'($urandom); pin_in = 16'($urandom);
      tx0_dat = r[12]; sda_dat = r[13]; scl_dat = r[14]; tx1_dat = r[15];
      step();
      check_all("R1");
      // data changes under a held map
      tx0_dat = ~tx0_dat; sda_dat = ~sda_dat; scl_dat = ~scl_dat; tx1_dat = ~tx1_dat;
      pin_in = ~pin_in; port_latch = ~port_latch;
      #1;
      check_drive();
      check_inputs();
    end

    finish_run();
  end
endmodule